// File: doc/BRIEF.md
# Radial Track-Crossing Counter with Jump Selection

This block counts track crossings for the radial servo of an optical disc drive. It takes two flags from the detector front end. One is an on-track flag, high while the spot lies within a quarter pitch of a track centre. The other is a polarity flag that runs about a quarter period apart from it. From these it keeps a signed crossing count relative to the track being followed, and it raises an off-track indication whenever that count is not zero. The radial loop uses the count to pull the spot back to its original track after a shock, and it uses the off-track indication to tell that the spot has left it.

The counter works inside one of two extension windows. In the narrow window it tolerates one crossing either side and re-centres when the spot goes further. In the wide window it tolerates two crossings either side, comes back to zero on the original track, and hands over to an access phase when the spot passes the window. There are three qualification states: a protected state with a programmable stability filter, a slow state with single-sample acceptance, and a fast state that counts raw rising edges of either the on-track flag or an external fast-count input in a commanded direction. A separate request pulse compares the number of tracks to go against the braking distance. It chooses a sledge jump or an actuator jump and holds that choice.

Top module: `track_cross_counter`

## Requirements
- R1: After synchronous reset the count is 0, `access_req` and `jump_valid` are 0, and `otd` sits at its inactive level (equal to `otd_inv`).
- R2: `otd` equals (count not zero) XOR `otd_inv`, so with `otd_inv`=1 the output is low while off track.
- R3: With `cnt_state` 2'b00 (protected) or 2'b01 (slow), each accepted rising edge of the qualified on-track flag moves the count by one. It moves up when `pol_in` is high at that edge and down when it is low. The count never moves by more than one per cycle, except when it clears to zero.
- R4: With `wide_ext`=0 (narrow window) the count stays within -1..+1. A crossing that would take it past the window clears it to 0.
- R5: With `wide_ext`=1 (wide window) the count runs within -2..+2 and reaches 0 again on the original track. A crossing past ±2 sets `access_req`, and while `access_req` is high the count moves without a window limit.
- R6: In the protected state a change of `on_trk` is accepted only after it has differed from the filtered level for `deb_n` consecutive cycles (`deb_n`=0 acts as 1). The slow state always uses 1. A shorter glitch leaves the count unchanged.
- R7: With `cnt_state` 2'b10 or 2'b11 (fast), every rising edge of the selected source moves the count one step in the direction of `fast_dir` (1 up, 0 down). The source is `ftc_in` when `use_ftc`=1 and `on_trk` otherwise. No filtering is applied, and an `on_trk` pulse has no effect while `ftc_in` is selected.
- R8: The count saturates at +32767 and -32768 (16-bit two's complement) and never wraps.
- R9: A one-cycle `go` latches `jump_sledge` = (`tracks_to_go` > `brake_dist`) and sets `jump_valid`. Equality selects the actuator jump (0). The choice holds until the next `go`.
- R10: A change of `wide_ext` clears the count and `access_req` on the following clock edge.
- R11: `go` clears `access_req` and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_trk | input | 1 | On-track flag from the front end |
| pol_in | input | 1 | Radial polarity flag |
| ftc_in | input | 1 | External fast track-count input |
| cnt_state | input | 2 | Qualification state: 00 protected, 01 slow, 1x fast |
| use_ftc | input | 1 | Fast state counts `ftc_in` instead of `on_trk` |
| fast_dir | input | 1 | Direction in the fast state (1 up) |
| wide_ext | input | 1 | 0 narrow window, 1 wide window |
| deb_n | input | 4 | Stability length for the protected state |
| otd_inv | input | 1 | Inverts the off-track output |
| go | input | 1 | One-cycle jump request |
| tracks_to_go | input | 15 | Unsigned tracks remaining |
| brake_dist | input | 15 | Unsigned braking distance |
| trk_count | output | 16 | Signed crossing count |
| otd | output | 1 | Off-track detect |
| access_req | output | 1 | Wide window exceeded, access phase |
| jump_valid | output | 1 | A jump choice has been latched |
| jump_sledge | output | 1 | 1 sledge jump, 0 actuator jump |

## Verification
The embedded properties take all flag inputs as synchronous to `clk`. They take `go` as a single-cycle strobe, and they take `wide_ext` as changing only between crossings, so that a clear is never mixed with a count step. The stimulus changes every input on the falling clock edge. It holds each on-track pulse and each gap for 20 cycles, which is wider than any programmed stability length, except for the deliberate short glitch. It lets at least three cycles pass after each window switch before the next crossing.

// File: rtl/trkc_pkg.sv
package trkc_pkg;

    typedef enum logic [1:0] {
        CS_PROT     = 2'b00,
        CS_SLOW     = 2'b01,
        CS_FAST     = 2'b10,
        CS_FAST_ALT = 2'b11
    } cnt_state_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

    localparam step_t STEP_IDLE = '{valid: 1'b0, up: 1'b0};

    function automatic logic state_is_fast(input cnt_state_e s);
        return (s == CS_FAST) || (s == CS_FAST_ALT);
    endfunction

    function automatic logic state_is_prot(input cnt_state_e s);
        return s == CS_PROT;
    endfunction

endpackage

// File: rtl/trkc_tpi_qual.sv
module trkc_tpi_qual
    import trkc_pkg::*;
#(
    parameter int DEB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_tpi,
    input  logic             ftc,
    input  logic             pol,
    input  logic             fast_dir,
    input  logic             use_ftc,
    input  cnt_state_e       state,
    input  logic [DEB_W-1:0] deb_n,
    output step_t            step
);
    localparam int RUN_W = DEB_W + 1;

    logic             filt;
    logic             filt_q;
    logic             src;
    logic             src_q;
    logic [DEB_W-1:0] run;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run_inc;
    logic             rise_qual;
    logic             rise_fast;

    always_comb begin
        if (state_is_prot(state) && (deb_n != '0))
            need = {1'b0, deb_n};
        else
            need = RUN_W'(1);
        run_inc = {1'b0, run} + RUN_W'(1);
        src     = use_ftc ? ftc : raw_tpi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt   <= 1'b0;
            filt_q <= 1'b0;
            src_q  <= 1'b0;
            run    <= '0;
        end else begin
            filt_q <= filt;
            src_q  <= src;
            if (raw_tpi != filt) begin
                if (run_inc >= need) begin
                    filt <= raw_tpi;
                    run  <= '0;
                end else begin
                    run  <= run_inc[DEB_W-1:0];
                end
            end else begin
                run <= '0;
            end
        end
    end

    assign rise_qual = filt & ~filt_q;
    assign rise_fast = src & ~src_q;

    always_comb begin
        step = STEP_IDLE;
        if (state_is_fast(state)) begin
            step.valid = rise_fast;
            step.up    = fast_dir;
        end else begin
            step.valid = rise_qual;
            step.up    = pol;
        end
    end

    // R6: the filtered level only ever moves to the raw level seen one cycle earlier
    assert_filter_follows_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt) |-> (filt == $past(raw_tpi)));

endmodule

// File: rtl/trkc_window_counter.sv
module trkc_window_counter
    import trkc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  step_t                   step,
    input  logic                    wide_ext,
    input  logic                    go,
    output logic signed [CNT_W-1:0] count,
    output logic                    access
);
    localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic signed [CNT_W-1:0] TWO  = CNT_W'(2);

    logic                    wide_q;
    logic signed [CNT_W-1:0] cnt_n;
    logic                    acc_n;
    logic signed [CNT_W-1:0] lim;
    logic                    beyond;

    function automatic logic signed [CNT_W-1:0] sat_step(
        input logic signed [CNT_W-1:0] c, input logic up);
        if (up)
            return (c == CMAX) ? CMAX : c + ONE;
        else
            return (c == CMIN) ? CMIN : c - ONE;
    endfunction

    always_comb begin
        lim    = wide_ext ? TWO : ONE;
        beyond = step.up ? (count >= lim) : (count <= -lim);
        cnt_n  = count;
        acc_n  = access;
        if (wide_ext != wide_q) begin
            cnt_n = '0;
            acc_n = 1'b0;
        end else begin
            if (go)
                acc_n = 1'b0;
            if (step.valid) begin
                if (access) begin
                    cnt_n = sat_step(count, step.up);
                end else if (beyond) begin
                    if (wide_ext) begin
                        acc_n = 1'b1;
                        cnt_n = sat_step(count, step.up);
                    end else begin
                        cnt_n = '0;
                    end
                end else begin
                    cnt_n = sat_step(count, step.up);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            access <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            count  <= cnt_n;
            access <= acc_n;
            wide_q <= wide_ext;
        end
    end

    // R3: one step per cycle at most, unless the count clears
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + ONE) ||
        (count == $past(count) - ONE) || (count == '0));

    // R4: narrow window bounds once the window has been narrow for a cycle
    assert_narrow_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (!wide_ext && ($past(wide_ext) == 1'b0)) |-> ((count <= ONE) && (count >= -ONE)));

    // R5: handover only ever starts from the wide window
    assert_access_from_wide_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(access) |-> $past(wide_ext));

    // R8: no wrap at either end
    assert_no_wrap_top_R8: assert property (@(posedge clk) disable iff (rst)
        (count == CMAX) |=> (count != CMIN));
    assert_no_wrap_bottom_R8: assert property (@(posedge clk) disable iff (rst)
        (count == CMIN) |=> (count != CMAX));

    // R10: a window switch clears the count
    assert_switch_clears_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(wide_ext) |=> ((count == '0) && !access));

endmodule

// File: rtl/trkc_jump_sel.sv
module trkc_jump_sel #(
    parameter int TTG_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [TTG_W-1:0] tracks_to_go,
    input  logic [TTG_W-1:0] brake_dist,
    output logic             jump_valid,
    output logic             jump_sledge
);
    always_ff @(posedge clk) begin
        if (rst) begin
            jump_valid  <= 1'b0;
            jump_sledge <= 1'b0;
        end else if (go) begin
            jump_valid  <= 1'b1;
            jump_sledge <= tracks_to_go > brake_dist;
        end
    end

    // R9: the choice holds between requests
    assert_choice_held_R9: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(jump_sledge));
    assert_valid_after_go_R9: assert property (@(posedge clk) disable iff (rst)
        go |=> jump_valid);

endmodule

// File: rtl/track_cross_counter.sv
module track_cross_counter
    import trkc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEB_W = 4,
    parameter int TTG_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             on_trk,
    input  logic             pol_in,
    input  logic             ftc_in,
    input  logic [1:0]       cnt_state,
    input  logic             use_ftc,
    input  logic             fast_dir,
    input  logic             wide_ext,
    input  logic [DEB_W-1:0] deb_n,
    input  logic             otd_inv,
    input  logic             go,
    input  logic [TTG_W-1:0] tracks_to_go,
    input  logic [TTG_W-1:0] brake_dist,
    output logic [CNT_W-1:0] trk_count,
    output logic             otd,
    output logic             access_req,
    output logic             jump_valid,
    output logic             jump_sledge
);
    cnt_state_e              state;
    step_t                   step;
    logic signed [CNT_W-1:0] count;

    assign state = cnt_state_e'(cnt_state);

    trkc_tpi_qual #(.DEB_W(DEB_W)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .raw_tpi  (on_trk),
        .ftc      (ftc_in),
        .pol      (pol_in),
        .fast_dir (fast_dir),
        .use_ftc  (use_ftc),
        .state    (state),
        .deb_n    (deb_n),
        .step     (step)
    );

    trkc_window_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .wide_ext (wide_ext),
        .go       (go),
        .count    (count),
        .access   (access_req)
    );

    trkc_jump_sel #(.TTG_W(TTG_W)) u_jump (
        .clk          (clk),
        .rst          (rst),
        .go           (go),
        .tracks_to_go (tracks_to_go),
        .brake_dist   (brake_dist),
        .jump_valid   (jump_valid),
        .jump_sledge  (jump_sledge)
    );

    assign trk_count = count;
    assign otd       = (count != '0) ^ otd_inv;

    // R11: a request ends the access phase
    assert_go_ends_access_R11: assert property (@(posedge clk) disable iff (rst)
        (go && !step.valid && ($past(wide_ext) == wide_ext)) |=> !access_req);

endmodule

// File: tb/track_cross_counter_bench.sv
module track_cross_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 190000;
    localparam int NVEC       = 10;

    // vector: [15] wide, [14:13] state, [12] dir, [11:8] pulses, [7:0] expected count
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 2'b01, 1'b1, 4'd1, 8'h01},   // R3 up, wide
        {1'b1, 2'b01, 1'b1, 4'd1, 8'h02},   // R5 to +2
        {1'b1, 2'b01, 1'b0, 4'd2, 8'h00},   // R5 back to origin
        {1'b1, 2'b00, 1'b0, 4'd2, 8'hFE},   // R3 protected down to -2
        {1'b1, 2'b00, 1'b1, 4'd1, 8'hFF},   // R3 protected up
        {1'b0, 2'b01, 1'b1, 4'd1, 8'h01},   // R10 clear then R4 +1
        {1'b0, 2'b01, 1'b1, 4'd1, 8'h00},   // R4 beyond window clears
        {1'b0, 2'b01, 1'b0, 4'd1, 8'hFF},   // R4 -1
        {1'b0, 2'b00, 1'b1, 4'd1, 8'h00},   // R3 protected back to 0
        {1'b0, 2'b10, 1'b0, 4'd1, 8'hFF}    // R7 fast on on_trk, down
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        on_trk = 1'b0, pol_in = 1'b0, ftc_in = 1'b0;
    logic [1:0]  cnt_state = 2'b01;
    logic        use_ftc = 1'b0, fast_dir = 1'b0, wide_ext = 1'b0;
    logic [3:0]  deb_n = 4'd4;
    logic        otd_inv = 1'b0, go = 1'b0;
    logic [14:0] tracks_to_go = '0, brake_dist = '0;
    logic [15:0] trk_count;
    logic        otd, access_req, jump_valid, jump_sledge;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    track_cross_counter u_track_cross_counter (
        .clk, .rst, .on_trk, .pol_in, .ftc_in, .cnt_state, .use_ftc, .fast_dir,
        .wide_ext, .deb_n, .otd_inv, .go, .tracks_to_go, .brake_dist,
        .trk_count, .otd, .access_req, .jump_valid, .jump_sledge
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cnt_now();
        return int'($signed(trk_count));
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tpi_pulse(input int width);
        on_trk = 1'b1;
        wait_cyc(width);
        on_trk = 1'b0;
        wait_cyc(20);
    endtask

    task automatic ftc_pulse();
        ftc_in = 1'b1;
        wait_cyc(1);
        ftc_in = 1'b0;
        wait_cyc(1);
    endtask

    task automatic set_wide(input logic w);
        if (wide_ext != w) begin
            wide_ext = w;
            wait_cyc(3);
        end
    endtask

    task automatic fire_go(input int ttg, input int bd);
        tracks_to_go = 15'(ttg);
        brake_dist   = 15'(bd);
        go = 1'b1;
        wait_cyc(1);
        go = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(4);
        // R1 reset state
        chk("R1", "count", cnt_now(), 0);
        chk("R1", "otd", int'(otd), 0);
        chk("R1", "access_req", int'(access_req), 0);
        chk("R1", "jump_valid", int'(jump_valid), 0);
        rst = 1'b0;
        wait_cyc(2);
        otd_inv = 1'b1;
        wait_cyc(1);
        chk("R2", "otd inverted on track", int'(otd), 1);
        otd_inv = 1'b0;
        wait_cyc(1);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            set_wide(VEC[i][15]);
            cnt_state = VEC[i][14:13];
            pol_in    = VEC[i][12];
            fast_dir  = VEC[i][12];
            wait_cyc(2);
            for (int p = 0; p < int'(VEC[i][11:8]); p++) tpi_pulse(20);
            chk("R3/R4/R5 vec", $sformatf("count[%0d]", i), cnt_now(),
                int'($signed(VEC[i][7:0])));
            chk("R2", $sformatf("otd[%0d]", i), int'(otd), int'(VEC[i][7:0] != 8'h00));
        end

        // R6 stability filter
        set_wide(1'b1);
        cnt_state = 2'b00;
        pol_in = 1'b1;
        deb_n = 4'd4;
        wait_cyc(2);
        tpi_pulse(3);
        chk("R6", "short glitch ignored", cnt_now(), 0);
        tpi_pulse(4);
        chk("R6", "stable pulse counted", cnt_now(), 1);
        otd_inv = 1'b1;
        wait_cyc(1);
        chk("R2", "otd inverted off track", int'(otd), 0);
        otd_inv = 1'b0;
        deb_n = 4'd0;
        wait_cyc(1);
        tpi_pulse(1);
        chk("R6", "zero length acts as one", cnt_now(), 2);

        // R5 handover
        cnt_state = 2'b01;
        deb_n = 4'd4;
        tpi_pulse(20);
        chk("R5", "count past window", cnt_now(), 3);
        chk("R5", "access_req", int'(access_req), 1);
        tpi_pulse(20);
        chk("R5", "free count in access", cnt_now(), 4);

        // R7 external fast source
        cnt_state = 2'b10;
        use_ftc = 1'b1;
        fast_dir = 1'b1;
        wait_cyc(2);
        for (int k = 0; k < 5; k++) ftc_pulse();
        tpi_pulse(20);
        wait_cyc(2);
        chk("R7", "ftc edges counted, on_trk ignored", cnt_now(), 9);

        // R9 / R11 jump choice
        fire_go(100, 50);
        chk("R9", "jump_valid", int'(jump_valid), 1);
        chk("R9", "sledge when larger", int'(jump_sledge), 1);
        chk("R11", "access cleared by go", int'(access_req), 0);
        chk("R11", "count kept by go", cnt_now(), 9);
        fire_go(50, 50);
        chk("R9", "equal picks actuator", int'(jump_sledge), 0);
        fire_go(32767, 32766);
        tracks_to_go = '0;
        wait_cyc(3);
        chk("R9", "choice held without go", int'(jump_sledge), 1);

        // R8 saturation
        set_wide(1'b0);
        set_wide(1'b1);
        chk("R10", "switch clears count", cnt_now(), 0);
        cnt_state = 2'b01;
        use_ftc = 1'b0;
        pol_in = 1'b1;
        wait_cyc(2);
        for (int k = 0; k < 3; k++) tpi_pulse(20);
        cnt_state = 2'b10;
        use_ftc = 1'b1;
        fast_dir = 1'b1;
        wait_cyc(2);
        for (int k = 0; k < 33000; k++) ftc_pulse();
        wait_cyc(3);
        chk("R8", "top saturation", cnt_now(), 32767);
        fast_dir = 1'b0;
        wait_cyc(1);
        ftc_pulse();
        ftc_pulse();
        wait_cyc(3);
        chk("R8", "no wrap after saturation", cnt_now(), 32765);

        // R10 window switch clears count and access
        set_wide(1'b0);
        chk("R10", "count cleared", cnt_now(), 0);
        chk("R10", "access cleared", int'(access_req), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule